// File: doc/BRIEF.md
# Pixel Hit Stream Reordering Decoder

This block sits between the readout of one pixel sensor module and the clustering stage. A module carries sixteen front-end chips in two rows of eight. They are numbered in a circle: 0 to 7 run along one row, and 8 to 15 come back along the other row in the opposite direction. The chips are read out one after another in ascending index. The chips of the lower half send their hits in descending column order. The upper half sends them in ascending order. Within a chip, hits of two adjacent columns come interleaved as a pair.

The decoder turns each chip-local hit (column 0..17, row 0..163) into module coordinates (column 0..143, row 0..327). Hits from upper-half chips pass straight through. Hits from lower-half chips are held on a last-in-first-out stack. When that chip's trailer word arrives, the stack is emitted in reverse, so the output runs in ascending column order. While the stack drains, the input is stalled. An end-of-event word leaves the block only after every held hit. Both sides are valid/ready streams, and the output is a single registered stage.

Top module: `pix_hit_reorder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1 for a hit word of an upper-half chip.
- R2: A hit (in_kind 0) from chip index c >= 8 leaves with out_col = (c-8)*18 + local column, out_row = local row, and out_tot unchanged.
- R3: A hit from chip index c < 8 leaves with out_col = (7-c)*18 + local column, out_row = 327 - local row, and out_tot unchanged.
- R4: Hits of upper-half chips leave in arrival order, one cycle after acceptance, without waiting for any trailer.
- R5: Hits of lower-half chips are held back. After a chip trailer (in_kind 1) is accepted, they leave in exact reverse order of arrival.
- R6: While held hits are draining, in_ready stays 0 for every word kind.
- R7: Chip trailers and reserved words (in_kind 3) are consumed and produce no output word.
- R8: An end-of-event word (in_kind 2) leaves as a word with out_last = 1 and zero coordinates. It follows every held hit of the event, including held hits whose trailer never came.
- R9: While out_valid is 1 and out_ready is 0, the output word holds steady.
- R10: When DEPTH hits are held, a further lower-half hit sees in_ready = 0, but a chip trailer is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| in_kind | input | 2 | 0 hit, 1 chip trailer, 2 end of event, 3 reserved |
| in_chip | input | 4 | Front-end chip index of a hit |
| in_col | input | 5 | Chip-local column |
| in_row | input | 8 | Chip-local row |
| in_tot | input | 4 | Charge (time over threshold) |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_last | output | 1 | Output word is the end-of-event marker |
| out_col | output | 8 | Module column |
| out_row | output | 9 | Module row |
| out_tot | output | 4 | Charge, passed through |

## Verification
The stack assertions take for granted two things about the input. The number of lower-half hits between trailers never exceeds the stack depth unless the producer waits on in_ready. Local columns and rows also stay inside one chip's 18 by 164 area. The random stimulus keeps within this: it draws coordinates only from that area and caps each lower-half chip's burst below the depth. A directed case fills the stack exactly and then offers one more hit. Trailers are dropped only for the last lower-half chip, so the end-of-event drain path runs without mixing two chips' hits beyond the depth.

// File: rtl/pix_reorder_pkg.sv
package pix_reorder_pkg;

    typedef enum logic [1:0] {
        K_HIT      = 2'd0,
        K_CHIP_END = 2'd1,
        K_EVT_END  = 2'd2,
        K_RSVD     = 2'd3
    } word_kind_e;

    typedef enum logic {
        M_PASS  = 1'b0,
        M_DRAIN = 1'b1
    } mode_e;

endpackage

// File: rtl/hit_coord_map.sv
module hit_coord_map #(
    parameter int CHIP_W    = 4,
    parameter int COL_W     = 5,
    parameter int ROW_W     = 8,
    parameter int OCOL_W    = 8,
    parameter int OROW_W    = 9,
    parameter int CHIP_COLS = 18,
    parameter int CHIP_ROWS = 164
) (
    input  logic [CHIP_W-1:0] chip,
    input  logic [COL_W-1:0]  lcol,
    input  logic [ROW_W-1:0]  lrow,
    output logic [OCOL_W-1:0] mcol,
    output logic [OROW_W-1:0] mrow,
    output logic              reversed
);
    localparam logic [OCOL_W-1:0] COLS_PER_CHIP = OCOL_W'(CHIP_COLS);
    localparam logic [OROW_W-1:0] ROW_TOP       = OROW_W'(2 * CHIP_ROWS - 1);

    logic [CHIP_W-2:0] slot;

    always_comb begin
        // lower half of the index range sits mirrored on the other row
        reversed = ~chip[CHIP_W-1];
        slot     = reversed ? ~chip[CHIP_W-2:0] : chip[CHIP_W-2:0];
        mcol     = OCOL_W'(slot) * COLS_PER_CHIP + OCOL_W'(lcol);
        mrow     = reversed ? (ROW_TOP - OROW_W'(lrow)) : OROW_W'(lrow);
    end
endmodule

// File: rtl/hit_lifo.sv
module hit_lifo #(
    parameter int W     = 21,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         one
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } lifo_st_t;

    lifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push)     st_d.cnt = st_q.cnt + CNT_W'(1);
        else if (pop) st_d.cnt = st_q.cnt - CNT_W'(1);
        empty = (st_q.cnt == '0);
        full  = (st_q.cnt == CNT_W'(DEPTH));
        one   = (st_q.cnt == CNT_W'(1));
        dout  = mem_q[AW'(st_q.cnt - CNT_W'(1))];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[AW'(st_q.cnt)] <= din;
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);

    // R6
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !push);
endmodule

// File: rtl/pix_hit_reorder.sv
module pix_hit_reorder
    import pix_reorder_pkg::*;
#(
    parameter int CHIP_W    = 4,
    parameter int COL_W     = 5,
    parameter int ROW_W     = 8,
    parameter int TOT_W     = 4,
    parameter int OCOL_W    = 8,
    parameter int OROW_W    = 9,
    parameter int CHIP_COLS = 18,
    parameter int CHIP_ROWS = 164,
    parameter int DEPTH     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_kind,
    input  logic [CHIP_W-1:0] in_chip,
    input  logic [COL_W-1:0]  in_col,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [TOT_W-1:0]  in_tot,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_last,
    output logic [OCOL_W-1:0] out_col,
    output logic [OROW_W-1:0] out_row,
    output logic [TOT_W-1:0]  out_tot
);
    localparam int HW = OCOL_W + OROW_W + TOT_W;

    typedef struct packed {
        mode_e             mode;
        logic              ovalid;
        logic              olast;
        logic [OCOL_W-1:0] ocol;
        logic [OROW_W-1:0] orow;
        logic [TOT_W-1:0]  otot;
    } state_t;

    state_t st_d, st_q;

    logic [OCOL_W-1:0] map_col;
    logic [OROW_W-1:0] map_row;
    logic              map_rev;
    logic              push, pop;
    logic [HW-1:0]     stk_in, stk_out;
    logic              stk_empty, stk_full, stk_one;
    logic              can_load, in_ready_c;
    word_kind_e        kind;

    hit_coord_map #(
        .CHIP_W(CHIP_W), .COL_W(COL_W), .ROW_W(ROW_W),
        .OCOL_W(OCOL_W), .OROW_W(OROW_W),
        .CHIP_COLS(CHIP_COLS), .CHIP_ROWS(CHIP_ROWS)
    ) i_map (
        .chip(in_chip), .lcol(in_col), .lrow(in_row),
        .mcol(map_col), .mrow(map_row), .reversed(map_rev)
    );

    assign stk_in = {map_col, map_row, in_tot};

    hit_lifo #(.W(HW), .DEPTH(DEPTH)) i_lifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .pop(pop),
        .din(stk_in), .dout(stk_out),
        .empty(stk_empty), .full(stk_full), .one(stk_one)
    );

    always_comb begin
        st_d       = st_q;
        push       = 1'b0;
        pop        = 1'b0;
        in_ready_c = 1'b0;
        kind       = word_kind_e'(in_kind);
        can_load   = !st_q.ovalid || out_ready;

        if (st_q.ovalid && out_ready) st_d.ovalid = 1'b0;

        unique case (st_q.mode)
            M_PASS: begin
                unique case (kind)
                    K_HIT: begin
                        if (map_rev) begin
                            in_ready_c = !stk_full;
                            push       = in_valid && !stk_full;
                        end else begin
                            in_ready_c = can_load;
                            if (in_valid && can_load) begin
                                st_d.ovalid = 1'b1;
                                st_d.olast  = 1'b0;
                                st_d.ocol   = map_col;
                                st_d.orow   = map_row;
                                st_d.otot   = in_tot;
                            end
                        end
                    end
                    K_CHIP_END: begin
                        in_ready_c = 1'b1;
                        if (in_valid && !stk_empty) st_d.mode = M_DRAIN;
                    end
                    K_EVT_END: begin
                        if (!stk_empty) begin
                            in_ready_c = 1'b0;
                            if (in_valid) st_d.mode = M_DRAIN;
                        end else begin
                            in_ready_c = can_load;
                            if (in_valid && can_load) begin
                                st_d.ovalid = 1'b1;
                                st_d.olast  = 1'b1;
                                st_d.ocol   = '0;
                                st_d.orow   = '0;
                                st_d.otot   = '0;
                            end
                        end
                    end
                    default: in_ready_c = 1'b1;
                endcase
            end
            M_DRAIN: begin
                if (stk_empty) begin
                    st_d.mode = M_PASS;
                end else if (can_load) begin
                    pop         = 1'b1;
                    st_d.ovalid = 1'b1;
                    st_d.olast  = 1'b0;
                    {st_d.ocol, st_d.orow, st_d.otot} = stk_out;
                    if (stk_one) st_d.mode = M_PASS;
                end
            end
            default: st_d.mode = M_PASS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready  = in_ready_c;
    assign out_valid = st_q.ovalid;
    assign out_last  = st_q.olast;
    assign out_col   = st_q.ocol;
    assign out_row   = st_q.orow;
    assign out_tot   = st_q.otot;

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable({out_last, out_col, out_row, out_tot})));

    // R8
    eoe_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_kind == 2'd2) |-> stk_empty);

    // R4
    fwd_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_kind == 2'd0 && in_chip[CHIP_W-1]) |=>
            (out_valid && !out_last));
endmodule

// File: tb/test_pix_hit_reorder.sv
module test_pix_hit_reorder;
    localparam int DEPTH = 8;

    logic       clk, rst_n;
    logic       in_valid, in_ready, out_valid, out_ready, out_last;
    logic [1:0] in_kind;
    logic [3:0] in_chip, in_tot, out_tot;
    logic [4:0] in_col;
    logic [7:0] in_row, out_col;
    logic [8:0] out_row;

    pix_hit_reorder #(.DEPTH(DEPTH)) i_pix_hit_reorder (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
        .in_chip(in_chip), .in_col(in_col), .in_row(in_row), .in_tot(in_tot),
        .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
        .out_col(out_col), .out_row(out_row), .out_tot(out_tot)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_errs   = 0;
    int ready_mode = 2;
    bit done = 0;

    logic [21:0] exp_q[$];
    string       tag_q[$];
    logic [21:0] rev_hold[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [21:0] map_hit(input int chip, input int col,
                                            input int row, input int tot);
        int c, r;
        if (chip < 8) begin c = (7 - chip) * 18 + col; r = 327 - row; end
        else          begin c = (chip - 8) * 18 + col; r = row; end
        return {1'b0, 8'(c), 9'(r), 4'(tot)};
    endfunction

    // output ready driver
    initial begin
        out_ready = 1'b0;
        forever begin
            @(negedge clk);
            case (ready_mode)
                0:       out_ready = ($urandom_range(0, 3) != 0);
                1:       out_ready = 1'b0;
                default: out_ready = 1'b1;
            endcase
        end
    end

    // output monitor
    initial begin
        bit          held = 0;
        logic [21:0] held_w = '0;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && out_valid) begin
                logic [21:0] cur;
                cur = {out_last, out_col, out_row, out_tot};
                if (held) chk(cur == held_w, "R9 output held under stall", int'(cur), int'(held_w));
                if (out_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R7 unexpected output word", int'(cur), 0);
                    end else begin
                        logic [21:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        chk(cur == e, t, int'(cur), int'(e));
                    end
                    held = 0;
                end else begin
                    held   = 1;
                    held_w = cur;
                end
            end else begin
                held = 0;
            end
        end
    end

    task automatic send(input logic [1:0] k, input int chip, input int col,
                        input int row, input int tot);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k;
        in_chip = 4'(chip); in_col = 5'(col); in_row = 8'(row); in_tot = 4'(tot);
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic peek(input logic [1:0] k, input int chip, input bit exp,
                        input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k;
        in_chip = 4'(chip); in_col = 5'd2; in_row = 8'd9; in_tot = 4'd1;
        #1;
        chk(in_ready == exp, tag, int'(in_ready), int'(exp));
    endtask

    task automatic put_hit(input int chip, input int col, input int row, input int tot);
        logic [21:0] w;
        w = map_hit(chip, col, row, tot);
        if (chip < 8) rev_hold.push_back(w);
        else begin
            exp_q.push_back(w);
            tag_q.push_back("R2 R4 upper-half hit");
        end
        send(2'd0, chip, col, row, tot);
    endtask

    task automatic put_trailer(input int chip);
        while (rev_hold.size() > 0) begin
            exp_q.push_back(rev_hold.pop_back());
            tag_q.push_back("R3 R5 lower-half hit reversed");
        end
        send(2'd1, chip, 0, 0, 0);
    endtask

    task automatic put_eoe();
        while (rev_hold.size() > 0) begin
            exp_q.push_back(rev_hold.pop_back());
            tag_q.push_back("R8 held hit before end word");
        end
        exp_q.push_back({1'b1, 21'd0});
        tag_q.push_back("R8 end word");
        send(2'd2, 0, 0, 0, 0);
    endtask

    task automatic wait_empty();
        int guard = 0;
        while (exp_q.size() > 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20140602));
        in_valid = 1'b0; in_kind = 2'd0; in_chip = 4'd8;
        in_col = '0; in_row = '0; in_tot = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

        // R2 / R3 single hits, corner coordinates
        ready_mode = 2;
        put_hit(9, 5, 100, 7);
        put_hit(15, 17, 163, 15);
        put_hit(0, 3, 10, 2);
        put_trailer(0);
        put_hit(7, 0, 0, 1);
        put_trailer(7);
        send(2'd3, 0, 0, 0, 0);          // R7 reserved word
        put_eoe();
        wait_empty();

        // R10 full stack, R6 stall while draining
        ready_mode = 1;
        for (int i = 0; i < DEPTH; i++) put_hit(3, 17 - 2 * i, 20 * i, i);
        peek(2'd0, 3, 1'b0, "R10 lower-half hit refused when stack full");
        @(negedge clk);
        in_valid = 1'b0;
        put_trailer(3);
        peek(2'd0, 10, 1'b0, "R6 upper-half hit stalled during drain");
        @(negedge clk);
        #1;
        chk(in_ready == 1'b0, "R6 still stalled next cycle", int'(in_ready), 0);
        chk(out_valid && out_col == 8'd75 && out_row == 9'd187,
            "R5 last held hit emitted first", int'(out_col), 75);
        in_valid = 1'b0;
        ready_mode = 2;
        wait_empty();

        // R8 end of event without trailer
        put_hit(5, 12, 40, 3);
        put_hit(5, 11, 41, 4);
        put_hit(5, 6, 42, 5);
        put_hit(12, 1, 50, 6);
        put_eoe();
        wait_empty();

        // random events with backpressure
        ready_mode = 0;
        for (int ev = 0; ev < 25; ev++) begin
            bit skip7;
            skip7 = ($urandom_range(0, 3) == 0);
            for (int chip = 0; chip < 16; chip++) begin
                int n, col;
                n   = $urandom_range(0, (chip < 8) ? 4 : 3);
                col = (chip < 8) ? 17 : 0;
                for (int h = 0; h < n; h++) begin
                    put_hit(chip, col, $urandom_range(0, 163), $urandom_range(0, 15));
                    if (chip < 8) col = (col > 2) ? col - $urandom_range(0, 2) : col;
                    else          col = (col < 15) ? col + $urandom_range(0, 2) : col;
                end
                if ($urandom_range(0, 7) == 0) send(2'd3, chip, 0, 0, 0);
                if (!(chip == 7 && skip7)) put_trailer(chip);
            end
            put_eoe();
        end
        ready_mode = 2;
        wait_empty();
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R8 every expected word delivered", exp_q.size(), 0);
        chk(out_valid == 1'b0, "R7 no stray output after trailers", int'(out_valid), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule